// File: doc/BRIEF.md
# Parallel EEPROM Write Controller Model

This block models the control logic of a byte-wide parallel EEPROM with 2048 words of 8 bits. A fast system clock samples the asynchronous chip-enable, output-enable and write-enable strobes through two-flop synchronizers. Edges are detected on the synchronized copies. The address and data buses are sampled directly in the clock domain.

A write pulse exists while chip enable and write enable are both low and output enable is high. The pulse starts when the later of the two strobes falls, and the address is captured at that moment. The pulse ends when the earlier of the two strobes rises, and the data is captured then. The byte is stored at that point and a self-timed programming interval follows, lasting `WR_CYCLES` clocks. While the interval runs, `busy_o` is high and the device ignores any new write.

A read of the byte last written during the interval returns its bit 7 inverted, which lets a host poll for completion. The storage array is plain registers with undefined contents after reset.

Top module: `eep_ctrl`

## Requirements
- R1: `data_oe_o` is 1 only while the synchronized chip enable and output enable are both low. It is 0 when either is high.
- R2: While `data_oe_o` is 1 and no programming interval covers `addr_i`, `data_o` shows the byte stored at `addr_i`.
- R3: A write stores at the address present when the later of chip enable and write enable falls, with output enable high. An address change after that moment has no effect.
- R4: The data stored is the value of `data_i` when the earlier of chip enable and write enable rises. A change of `data_i` after that rise has no effect.
- R5: `busy_o` rises the clock after the data capture and stays high for exactly `WR_CYCLES` clocks.
- R6: While `busy_o` is 1, a read of the last written address returns bit 7 inverted and bits 6:0 true. A read of any other address returns true data.
- R7: Once `busy_o` has fallen, a read of the last written address returns the true stored byte.
- R8: A write pulse that begins while `busy_o` is 1 is ignored. No location changes and the interval is not extended.
- R9: With chip enable, output enable and write enable all low, no write happens and `busy_o` stays 0.
- R10: With chip enable high, write-enable pulses start no write and `data_oe_o` stays 0.
- R11: After reset, `busy_o` and `data_oe_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ce_ni | input | 1 | Chip enable, active low, asynchronous |
| oe_ni | input | 1 | Output enable, active low, asynchronous |
| we_ni | input | 1 | Write enable, active low, asynchronous |
| addr_i | input | 11 | Word address |
| data_i | input | 8 | Write data bus |
| data_o | output | 8 | Read data bus |
| data_oe_o | output | 1 | Output driver enable; 0 means high impedance |
| busy_o | output | 1 | Programming interval in progress |

## Verification
The hardest situations to reach are the two edge-ordering cases, because each needs a bus change placed between the two strobe edges.

- For R3, write enable falls first with a decoy address on the bus. The address then changes, and chip enable falls later.
- For R4, chip enable rises first. The data then changes, and write enable rises later.

The gap between events is wider than the synchronizer latency, so each edge is seen on its own. Data polling and busy-time writes are driven inside the programming interval, right after a write, before `busy_o` falls.

// File: rtl/eep_pkg.sv
package eep_pkg;
  typedef enum logic [1:0] {
    WS_IDLE  = 2'd0,
    WS_ARMED = 2'd1,
    WS_PROG  = 2'd2
  } wr_state_e;
endpackage

// File: rtl/eep_sync.sv
module eep_sync #(
  parameter int unsigned W = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    logic s1_q, s2_q;
    // strobes are active low: reset to idle level
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q <= 1'b1;
        s2_q <= 1'b1;
      end else begin
        s1_q <= async_i[g];
        s2_q <= s1_q;
      end
    end
    assign sync_o[g] = s2_q;
  end
endmodule

// File: rtl/eep_wr_ctl.sv
module eep_wr_ctl
  import eep_pkg::*;
#(
  parameter int unsigned AW        = 11,
  parameter int unsigned DW        = 8,
  parameter int unsigned WR_CYCLES = 64
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ce_s_i,
  input  logic          oe_s_i,
  input  logic          we_s_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] data_i,
  output logic          wr_en_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [DW-1:0] wr_data_o,
  output logic          busy_o
);
  localparam int unsigned CW = $clog2(WR_CYCLES + 1);

  wr_state_e     state_q;
  logic          pulse, pulse_q;
  logic [AW-1:0] addr_q;
  logic [CW-1:0] cnt_q;

  assign pulse     = !ce_s_i && !we_s_i && oe_s_i;
  // pulse ended by a CE or WE rise, not by OE dropping
  assign wr_en_o   = (state_q == WS_ARMED) && !pulse && oe_s_i;
  assign wr_addr_o = addr_q;
  assign wr_data_o = data_i;
  assign busy_o    = (state_q == WS_PROG);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= WS_IDLE;
      pulse_q <= 1'b0;
      addr_q  <= '0;
      cnt_q   <= '0;
    end else begin
      pulse_q <= pulse;
      unique case (state_q)
        WS_IDLE: begin
          if (pulse && !pulse_q) begin
            addr_q  <= addr_i;
            state_q <= WS_ARMED;
          end
        end
        WS_ARMED: begin
          if (wr_en_o) begin
            cnt_q   <= CW'(WR_CYCLES - 1);
            state_q <= WS_PROG;
          end else if (!pulse) begin
            state_q <= WS_IDLE;
          end
        end
        WS_PROG: begin
          if (cnt_q == '0) state_q <= WS_IDLE;
          else             cnt_q   <= cnt_q - 1'b1;
        end
        default: state_q <= WS_IDLE;
      endcase
    end
  end

  logic [CW-1:0] blen_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     blen_q <= '0;
    else if (busy_o) blen_q <= blen_q + 1'b1;
    else             blen_q <= '0;
  end

  AST_BUSY_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> blen_q == CW'(WR_CYCLES)); // R5
  AST_BUSY_FROM_COMMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(wr_en_o)); // R4
  AST_COMMIT_OE_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> oe_s_i && !busy_o); // R9
endmodule

// File: rtl/eep_array.sv
module eep_array #(
  parameter int unsigned AW = 11,
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];

  AST_WADDR_KNOWN: assert property (@(posedge clk_i)
    we_i |-> !$isunknown(waddr_i)); // R3
endmodule

// File: rtl/eep_ctrl.sv
module eep_ctrl #(
  parameter int unsigned AW        = 11,
  parameter int unsigned DW        = 8,
  parameter int unsigned WR_CYCLES = 64
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ce_ni,
  input  logic          oe_ni,
  input  logic          we_ni,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] data_i,
  output logic [DW-1:0] data_o,
  output logic          data_oe_o,
  output logic          busy_o
);
  logic [2:0]    strb_s;
  logic          ce_s, oe_s, we_s;
  logic          wr_en;
  logic [AW-1:0] wr_addr;
  logic [DW-1:0] wr_data, rd_data, rd_mux;
  logic [DW-1:0] data_q;
  logic          oe_q;

  eep_sync #(.W(3)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .async_i({ce_ni, oe_ni, we_ni}),
    .sync_o (strb_s)
  );
  assign {ce_s, oe_s, we_s} = strb_s;

  eep_wr_ctl #(.AW(AW), .DW(DW), .WR_CYCLES(WR_CYCLES)) u_wr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ce_s_i   (ce_s),
    .oe_s_i   (oe_s),
    .we_s_i   (we_s),
    .addr_i   (addr_i),
    .data_i   (data_i),
    .wr_en_o  (wr_en),
    .wr_addr_o(wr_addr),
    .wr_data_o(wr_data),
    .busy_o   (busy_o)
  );

  eep_array #(.AW(AW), .DW(DW)) u_mem (
    .clk_i  (clk_i),
    .we_i   (wr_en),
    .waddr_i(wr_addr),
    .wdata_i(wr_data),
    .raddr_i(addr_i),
    .rdata_o(rd_data)
  );

  // data polling: top bit inverted on the byte being programmed
  always_comb begin
    rd_mux = rd_data;
    if (busy_o && addr_i == wr_addr) rd_mux[DW-1] = ~rd_data[DW-1];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      oe_q   <= 1'b0;
    end else begin
      data_q <= rd_mux;
      oe_q   <= !ce_s && !oe_s;
    end
  end

  assign data_o    = data_q;
  assign data_oe_o = oe_q;

  AST_RD_NEEDS_CE_OE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_oe_o |-> $past(!ce_s && !oe_s)); // R1
  AST_STANDBY_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ce_s |=> !data_oe_o); // R10
  AST_NO_WR_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !wr_en); // R8
  AST_BUSY_STAYS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |=> busy_o); // R5
endmodule

// File: tb/eep_ctrl_tb.sv
`timescale 1ns/1ps
module eep_ctrl_tb_top;
  localparam int unsigned WRC = 200;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       ce_ni = 1'b1, oe_ni = 1'b1, we_ni = 1'b1;
  logic [10:0] addr_i = '0;
  logic [7:0]  data_i = '0;
  logic [7:0]  data_o;
  logic        data_oe_o, busy_o;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2 clk_i = ~clk_i;

  eep_ctrl #(.AW(11), .DW(8), .WR_CYCLES(WRC)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .ce_ni(ce_ni), .oe_ni(oe_ni), .we_ni(we_ni),
    .addr_i(addr_i), .data_i(data_i), .data_o(data_o),
    .data_oe_o(data_oe_o), .busy_o(busy_o)
  );

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  // scoreboard
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic       smp_req = 1'b0;

  initial begin
    forever begin
      @(posedge smp_req);
      @(negedge clk_i);
      chk({7'd0, data_oe_o}, 8'd1, {tag_q[0], " oe"});
      chk(data_o, exp_q[0], tag_q[0]);
      void'(exp_q.pop_front());
      void'(tag_q.pop_front());
    end
  end

  task automatic rd(input logic [10:0] a, input logic [7:0] exp, input string tag);
    addr_i = a; ce_ni = 1'b0; oe_ni = 1'b0; we_ni = 1'b1;
    cyc(6);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    smp_req = 1'b1;
    cyc(1);
    smp_req = 1'b0;
    cyc(1);
    ce_ni = 1'b1; oe_ni = 1'b1;
    cyc(4);
  endtask

  // write-enable controlled: CE falls first, WE falls last and rises first
  task automatic wr(input logic [10:0] a, input logic [7:0] d);
    oe_ni = 1'b1; ce_ni = 1'b0; cyc(4);
    addr_i = a; data_i = d; we_ni = 1'b0; cyc(5);
    we_ni = 1'b1; cyc(5);
    ce_ni = 1'b1; cyc(2);
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 4 * WRC && busy_o; i++) cyc(1);
    cyc(2);
  endtask

  // busy-length monitor
  int blen = 0;
  initial begin
    forever begin
      @(negedge clk_i);
      if (busy_o) blen++;
      else if (blen != 0) begin
        chk(8'(blen), 8'(WRC), "R5 busy length");
        blen = 0;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!finished) begin
      finished = 1;
      bad++; total++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    cyc(3);
    chk({7'd0, busy_o}, 8'd0, "R11 busy");
    chk({7'd0, data_oe_o}, 8'd0, "R11 oe");
    rst_ni = 1'b1;
    cyc(4);

    // basic write with polling (bit7 written 1)
    wr(11'h010, 8'hA5);
    chk({7'd0, busy_o}, 8'd1, "R5 busy after write");
    rd(11'h010, 8'h25, "R6 poll bit7 high");
    wait_idle();
    rd(11'h010, 8'hA5, "R7 true data after busy");

    // polling with bit7 written 0, other address true during busy
    wr(11'h005, 8'h7F);
    rd(11'h005, 8'hFF, "R6 poll bit7 low");
    rd(11'h010, 8'hA5, "R6 other addr true");
    wait_idle();
    rd(11'h005, 8'h7F, "R7 true data 7F");

    // extreme addresses
    wr(11'h7FF, 8'h80); wait_idle();
    wr(11'h000, 8'h01); wait_idle();
    rd(11'h7FF, 8'h80, "R2 top addr");
    rd(11'h000, 8'h01, "R2 bottom addr");

    // CE-controlled ordering: WE falls first, CE falls last and rises first
    wr(11'h020, 8'h11); wait_idle();
    oe_ni = 1'b1; addr_i = 11'h020; we_ni = 1'b0; cyc(5);
    addr_i = 11'h021; data_i = 8'h3C; ce_ni = 1'b0; cyc(5);
    addr_i = 11'h020; ce_ni = 1'b1; cyc(5);
    data_i = 8'hC3; cyc(2); we_ni = 1'b1; cyc(3);
    wait_idle();
    rd(11'h021, 8'h3C, "R3 R4 ce-controlled");
    rd(11'h020, 8'h11, "R3 decoy addr untouched");

    // busy-time write ignored
    wr(11'h030, 8'h55); wait_idle();
    wr(11'h040, 8'h01);
    wr(11'h030, 8'hAA);
    wait_idle();
    rd(11'h030, 8'h55, "R8 write during busy ignored");
    rd(11'h040, 8'h01, "R8 first write kept");

    // inhibit: all three low
    addr_i = 11'h030; data_i = 8'h99;
    oe_ni = 1'b0; cyc(4); ce_ni = 1'b0; cyc(4); we_ni = 1'b0; cyc(6);
    we_ni = 1'b1; cyc(4); oe_ni = 1'b1; cyc(4); ce_ni = 1'b1; cyc(6);
    chk({7'd0, busy_o}, 8'd0, "R9 no busy on inhibit");
    rd(11'h030, 8'h55, "R9 inhibit keeps data");

    // standby: CE high
    addr_i = 11'h030; data_i = 8'h77; oe_ni = 1'b1;
    we_ni = 1'b0; cyc(6); we_ni = 1'b1; cyc(6);
    chk({7'd0, busy_o}, 8'd0, "R10 no busy in standby");
    oe_ni = 1'b0; cyc(6);
    chk({7'd0, data_oe_o}, 8'd0, "R10 oe low in standby");
    oe_ni = 1'b1; ce_ni = 1'b0; cyc(6);
    chk({7'd0, data_oe_o}, 8'd0, "R1 output disabled with OE high");
    ce_ni = 1'b1; cyc(4);
    rd(11'h030, 8'h55, "R10 standby keeps data");

    cyc(4);
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule